// File: doc/BRIEF.md
# FIFO Configuration Word Sequencer

This block gives a host access to the configuration words of a FIFO through the FIFO's own data ports. There are three words: the almost-empty threshold, the almost-full threshold, and a control word that only enhanced mode reaches. A select input, `cfg_sel_n`, decides where write and read cycles go. When it is low, an enabled write cycle stores the input data into a configuration word. An enabled read cycle places a configuration word on the readback bus. When it is high, the same enables go to the memory array, which lives outside this block.

There is no address. The write side and the read side each have their own cursor, and the cursor steps through the words in a fixed ring. In compatible mode the ring has two words. In enhanced mode it has three. When bit 0 of the control word is set in enhanced mode, a cursor can be sent back to the first word. This happens when `cfg_sel_n` goes from low to high and an array cycle follows on that cursor's side. A write to a threshold word while the FIFO holds data is flagged on an error output, but the write is not blocked.

Top module: `cfg_word_seq`

## Requirements
- R1: When `cfg_sel_n`=0 and `wr_en_n`=0 at a `wclk` edge, the word picked by the write cursor takes `din`. Word 0 is the almost-empty threshold and takes `din[OFS_W-1:0]`. Word 1 is the almost-full threshold and takes `din[OFS_W-1:0]`. Word 2 is the control word and takes all of `din`. The write cursor then advances.
- R2: When `cfg_sel_n`=0 and `rd_en_n`=0 at an `rclk` edge, `cfg_rdata` shows the word picked by the read cursor from that edge on, zero-extended for the thresholds. At all other edges `cfg_rdata` holds its value.
- R3: While `cfg_sel_n`=1, the enables act on the array. No configuration word changes, `cfg_rdata` holds, and a cursor either stays put or rewinds to word 0 (R8).
- R4: A read does not move the write cursor, and a write does not move the read cursor.
- R5: Synchronous active-high `rst` sets both cursors to word 0 and sets the thresholds to `AE_RST` and `AF_RST`. It clears the control word and `cfg_rdata`.
- R6: With `enh_mode`=0, each cursor steps word 0, then word 1, then word 0 again. Word 2 is never written or read.
- R7: With `enh_mode`=1, each cursor steps word 0, then word 1, then word 2, then word 0.
- R8: With `enh_mode`=1 and control bit 0 set, a rise of `cfg_sel_n` is remembered. The next array write (`cfg_sel_n`=1, `wr_en_n`=0) sends the write cursor to word 0. The next array read does the same for the read cursor. An array cycle in the same cycle as the rise counts.
- R9: With `enh_mode`=0, or with control bit 0 clear, array cycles never move a cursor.
- R10: When `cfg_sel_n`=0 and the side's enable is high, that cursor holds and no word is accessed.
- R11: A configuration write to word 0 or word 1 while `fifo_empty`=0 raises `cfg_wr_err` for exactly the next `wclk` cycle, and the write still takes effect. Writes to the control word never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| enh_mode | input | 1 | 1 = enhanced mode (three-word ring), 0 = compatible mode |
| cfg_sel_n | input | 1 | 0 = cycles go to configuration words, 1 = cycles go to the array |
| wr_en_n | input | 1 | Active-low write enable |
| rd_en_n | input | 1 | Active-low read enable |
| din | input | DATA_W | Write data |
| fifo_empty | input | 1 | FIFO empty indication, in the `wclk` domain |
| cfg_rdata | output | DATA_W | Configuration readback |
| ae_ofs | output | OFS_W | Current almost-empty threshold |
| af_ofs | output | OFS_W | Current almost-full threshold |
| ctrl_word | output | DATA_W | Current control word |
| cfg_wr_err | output | 1 | One-cycle flag for a threshold write to a non-empty FIFO |

## Verification
On every clock, the embedded assertions check the following:
- Cursors stay legal, and word 2 stays unreachable in compatible mode.
- A cursor holds when its enable is off in configuration mode.
- Array cycles only hold a cursor or send it to word 0, and a qualified rewind lands on word 0.
- The stored words and the readback change only on an enabled configuration cycle.
- The error flag only follows a threshold write with the FIFO not empty.

Only the bench's scenarios can show the actual ring order and which word a given write or read lands on. The same goes for the independence of the two cursors, for rewind being suppressed in compatible mode or with the control bit clear, and for a flagged write still storing its data. A behavioural model compares every output on every clock.

// File: rtl/cfg_word_seq_pkg.sv
package cfg_word_seq_pkg;

    // Cursor positions; the ring order depends on these codes.
    typedef enum logic [1:0] {
        SEL_AE   = 2'd0,
        SEL_AF   = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_BAD  = 2'd3
    } word_sel_e;

    // Decoded meaning of one side's inputs in one cycle.
    typedef struct packed {
        logic cfg_hit;   // configuration word access
        logic arr_hit;   // array access
    } acc_t;

    localparam int unsigned REWIND_BIT = 0;

    function automatic acc_t decode_acc(input logic sel_n, input logic en_n);
        acc_t a;
        a.cfg_hit = !sel_n && !en_n;
        a.arr_hit =  sel_n && !en_n;
        return a;
    endfunction

    // Next ring position: two words in compatible mode, three in enhanced.
    function automatic word_sel_e sel_next(input word_sel_e cur, input logic enh);
        word_sel_e last;
        last = enh ? SEL_CTRL : SEL_AF;
        if (cur >= last)
            return SEL_AE;
        return word_sel_e'(cur + 2'd1);
    endfunction

endpackage

// File: rtl/cfg_word_cursor.sv
module cfg_word_cursor
    import cfg_word_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enh,
    input  logic      rew_en,
    input  logic      sel_n,
    input  logic      en_n,
    output word_sel_e cur,
    output logic      cfg_hit
);

    acc_t acc;
    logic sel_q;
    logic pend;
    logic rising;
    logic rewind;

    assign acc     = decode_acc(sel_n, en_n);
    assign cfg_hit = acc.cfg_hit;
    assign rising  = sel_n && !sel_q;
    assign rewind  = acc.arr_hit && (pend || rising) && enh && rew_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= SEL_AE;
            pend  <= 1'b0;
            sel_q <= 1'b1;
        end else begin
            sel_q <= sel_n;
            if (acc.cfg_hit)
                cur <= sel_next(cur, enh);
            else if (rewind)
                cur <= SEL_AE;
            if (acc.arr_hit)
                pend <= 1'b0;
            else if (rising)
                pend <= 1'b1;
        end
    end

    AST_CURSOR_LEGAL: assert property (@(posedge clk) disable iff (rst)
        cur != SEL_BAD);                                             // R7
    AST_CURSOR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!sel_n && en_n) |=> $stable(cur));                          // R10
    AST_ARRAY_NO_STEP: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> (cur == $past(cur) || cur == SEL_AE));             // R3
    AST_COMPAT_NO_W2: assert property (@(posedge clk) disable iff (rst)
        (!enh && $past(!enh) && $past(cur != SEL_CTRL)) |-> cur != SEL_CTRL); // R6
    AST_REWIND_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc.arr_hit && (pend || rising) && enh && rew_en) |=> cur == SEL_AE); // R8

endmodule

// File: rtl/cfg_word_regs.sv
module cfg_word_regs
    import cfg_word_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned OFS_W  = 12,
    parameter int unsigned AE_RST = 16,
    parameter int unsigned AF_RST = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  word_sel_e         wr_sel,
    input  logic [DATA_W-1:0] din,
    input  logic              fifo_empty,
    output logic [OFS_W-1:0]  ae,
    output logic [OFS_W-1:0]  af,
    output logic [DATA_W-1:0] ctrl,
    output logic              err
);

    logic ofs_target;
    assign ofs_target = (wr_sel == SEL_AE) || (wr_sel == SEL_AF);

    always_ff @(posedge clk) begin
        if (rst) begin
            ae   <= OFS_W'(AE_RST);
            af   <= OFS_W'(AF_RST);
            ctrl <= '0;
            err  <= 1'b0;
        end else begin
            err <= wr_hit && ofs_target && !fifo_empty;
            if (wr_hit) begin
                unique case (wr_sel)
                    SEL_AE:   ae   <= din[OFS_W-1:0];
                    SEL_AF:   af   <= din[OFS_W-1:0];
                    SEL_CTRL: ctrl <= din;
                    default:  ;
                endcase
            end
        end
    end

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        err |-> ($past(wr_hit) && $past(wr_sel != SEL_CTRL) && !$past(fifo_empty))); // R11
    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> ($stable(ae) && $stable(af) && $stable(ctrl)));  // R3

endmodule

// File: rtl/cfg_word_readback.sv
module cfg_word_readback
    import cfg_word_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned OFS_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_hit,
    input  word_sel_e         rd_sel,
    input  logic [OFS_W-1:0]  ae,
    input  logic [OFS_W-1:0]  af,
    input  logic [DATA_W-1:0] ctrl,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned PAD_W = DATA_W - OFS_W;

    logic [DATA_W-1:0] picked;

    always_comb begin
        unique case (rd_sel)
            SEL_AE:   picked = {{PAD_W{1'b0}}, ae};
            SEL_AF:   picked = {{PAD_W{1'b0}}, af};
            SEL_CTRL: picked = ctrl;
            default:  picked = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_hit)
            rdata <= picked;
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |=> $stable(rdata));                                 // R2

endmodule

// File: rtl/cfg_word_seq.sv
module cfg_word_seq
    import cfg_word_seq_pkg::*;
#(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned OFS_W  = 12,
    parameter int unsigned AE_RST = 16,
    parameter int unsigned AF_RST = 32
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic              enh_mode,
    input  logic              cfg_sel_n,
    input  logic              wr_en_n,
    input  logic              rd_en_n,
    input  logic [DATA_W-1:0] din,
    input  logic              fifo_empty,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic [OFS_W-1:0]  ae_ofs,
    output logic [OFS_W-1:0]  af_ofs,
    output logic [DATA_W-1:0] ctrl_word,
    output logic              cfg_wr_err
);

    localparam int unsigned N_SIDES = 2;
    localparam int unsigned SIDE_W  = 0;
    localparam int unsigned SIDE_R  = 1;

    logic      side_clk [N_SIDES];
    logic      side_en_n[N_SIDES];
    word_sel_e side_cur [N_SIDES];
    logic      side_hit [N_SIDES];
    logic      rew_en;

    assign side_clk[SIDE_W]  = wclk;
    assign side_clk[SIDE_R]  = rclk;
    assign side_en_n[SIDE_W] = wr_en_n;
    assign side_en_n[SIDE_R] = rd_en_n;
    assign rew_en            = ctrl_word[REWIND_BIT];

    for (genvar s = 0; s < N_SIDES; s++) begin : g_side
        cfg_word_cursor u_cursor (
            .clk     (side_clk[s]),
            .rst     (rst),
            .enh     (enh_mode),
            .rew_en  (rew_en),
            .sel_n   (cfg_sel_n),
            .en_n    (side_en_n[s]),
            .cur     (side_cur[s]),
            .cfg_hit (side_hit[s])
        );
    end

    cfg_word_regs #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W),
        .AE_RST (AE_RST),
        .AF_RST (AF_RST)
    ) u_regs (
        .clk        (wclk),
        .rst        (rst),
        .wr_hit     (side_hit[SIDE_W]),
        .wr_sel     (side_cur[SIDE_W]),
        .din        (din),
        .fifo_empty (fifo_empty),
        .ae         (ae_ofs),
        .af         (af_ofs),
        .ctrl       (ctrl_word),
        .err        (cfg_wr_err)
    );

    cfg_word_readback #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_readback (
        .clk    (rclk),
        .rst    (rst),
        .rd_hit (side_hit[SIDE_R]),
        .rd_sel (side_cur[SIDE_R]),
        .ae     (ae_ofs),
        .af     (af_ofs),
        .ctrl   (ctrl_word),
        .rdata  (cfg_rdata)
    );

endmodule

// File: tb/cfg_word_seq_test.sv
module cfg_word_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 18;
    localparam int OFS_W      = 12;
    localparam int AE_RST     = 16;
    localparam int AF_RST     = 32;
    localparam int OFS_MASK   = (1 << OFS_W) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              enh_mode = 1'b0;
    logic              cfg_sel_n = 1'b1;
    logic              wr_en_n = 1'b1;
    logic              rd_en_n = 1'b1;
    logic [DATA_W-1:0] din = '0;
    logic              fifo_empty = 1'b1;
    logic [DATA_W-1:0] cfg_rdata;
    logic [OFS_W-1:0]  ae_ofs;
    logic [OFS_W-1:0]  af_ofs;
    logic [DATA_W-1:0] ctrl_word;
    logic              cfg_wr_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_word_seq #(
        .DATA_W (DATA_W), .OFS_W (OFS_W), .AE_RST (AE_RST), .AF_RST (AF_RST)
    ) uut (
        .wclk (clk), .rclk (clk), .rst (rst), .enh_mode (enh_mode),
        .cfg_sel_n (cfg_sel_n), .wr_en_n (wr_en_n), .rd_en_n (rd_en_n),
        .din (din), .fifo_empty (fifo_empty), .cfg_rdata (cfg_rdata),
        .ae_ofs (ae_ofs), .af_ofs (af_ofs), .ctrl_word (ctrl_word),
        .cfg_wr_err (cfg_wr_err)
    );

    task automatic check(input string tag, input int actual, input int expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, actual, expected);
        end
    endtask

    // Behavioural reference model.
    int  m_words[3];
    int  m_wcur, m_rcur, m_rdata, m_err;
    bit  m_wpend, m_rpend, m_prev_sel, m_live = 0;

    function automatic int step_ring(input int c, input bit enh);
        int last;
        last = enh ? 2 : 1;
        return (c >= last) ? 0 : c + 1;
    endfunction

    always @(posedge clk) begin
        int old[3];
        bit rise, rew;
        if (rst) begin
            m_words = '{AE_RST, AF_RST, 0};
            m_wcur = 0; m_rcur = 0; m_rdata = 0; m_err = 0;
            m_wpend = 0; m_rpend = 0; m_prev_sel = 1; m_live = 1;
        end else begin
            old  = m_words;
            rise = cfg_sel_n && !m_prev_sel;
            rew  = enh_mode && old[0+2][0];
            // read side uses pre-edge word values
            if (!cfg_sel_n && !rd_en_n) begin
                m_rdata = old[m_rcur];
                m_rcur  = step_ring(m_rcur, enh_mode);
            end else if (cfg_sel_n && !rd_en_n) begin
                if ((m_rpend || rise) && rew) m_rcur = 0;
                m_rpend = 0;
            end else if (rise) m_rpend = 1;
            // write side
            m_err = 0;
            if (!cfg_sel_n && !wr_en_n) begin
                m_words[m_wcur] = (m_wcur == 2) ? int'(din) : (int'(din) & OFS_MASK);
                m_err  = (m_wcur < 2) && !fifo_empty;
                m_wcur = step_ring(m_wcur, enh_mode);
            end else if (cfg_sel_n && !wr_en_n) begin
                if ((m_wpend || rise) && rew) m_wcur = 0;
                m_wpend = 0;
            end else if (rise) m_wpend = 1;
            m_prev_sel = cfg_sel_n;
        end
    end

    always @(negedge clk) begin
        if (m_live) begin
            check("R1 model ae",     int'(ae_ofs),     m_words[0]);
            check("R1 model af",     int'(af_ofs),     m_words[1]);
            check("R1 model ctrl",   int'(ctrl_word),  m_words[2]);
            check("R2 model rdata",  int'(cfg_rdata),  m_rdata);
            check("R11 model err",   int'(cfg_wr_err), m_err);
        end
    end

    task automatic cyc(input logic s, input logic w, input logic r, input int d);
        cfg_sel_n = s; wr_en_n = w; rd_en_n = r; din = DATA_W'(d);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int d);  cyc(1'b0, 1'b0, 1'b1, d); endtask
    task automatic rd();             cyc(1'b0, 1'b1, 1'b0, 0); endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R5 reset state
        check("R5 ae reset",    int'(ae_ofs),    AE_RST);
        check("R5 af reset",    int'(af_ofs),    AF_RST);
        check("R5 ctrl reset",  int'(ctrl_word), 0);
        check("R5 rdata reset", int'(cfg_rdata), 0);

        // R6 compatible ring, R1 masking
        wr('h00011); wr('h00022); wr('h3FF33);
        check("R6 ae wrapped write", int'(ae_ofs), 'hF33);
        check("R1 af write",         int'(af_ofs), 'h022);
        check("R6 ctrl untouched",   int'(ctrl_word), 0);
        rd(); check("R6 read w0", int'(cfg_rdata), 'hF33);
        rd(); check("R6 read w1", int'(cfg_rdata), 'h022);
        rd(); check("R2 read w0 again", int'(cfg_rdata), 'hF33);

        // R10 hold with enables off
        repeat (3) cyc(1'b0, 1'b1, 1'b1, 'h2AAAA);
        check("R10 rdata held", int'(cfg_rdata), 'hF33);
        check("R10 ae held",    int'(ae_ofs),    'hF33);
        wr('h00055);
        check("R10 write cursor held at w1", int'(af_ofs), 'h055);

        // R3 array cycles, R9 no rewind in compatible mode
        cyc(1'b1, 1'b0, 1'b0, 'h3FFFF);
        cyc(1'b1, 1'b0, 1'b0, 'h3FFFF);
        check("R3 ae unchanged",    int'(ae_ofs),    'hF33);
        check("R3 af unchanged",    int'(af_ofs),    'h055);
        check("R3 rdata unchanged", int'(cfg_rdata), 'hF33);
        rd(); check("R9 read cursor not rewound", int'(cfg_rdata), 'h055);

        // R7 enhanced ring
        enh_mode = 1'b1;
        wr('h00101); wr('h00202); wr('h00001); wr('h00303);
        check("R7 ctrl reached", int'(ctrl_word), 'h00001);
        check("R7 wrap to w0",   int'(ae_ofs),    'h303);
        rd(); check("R7 read w0", int'(cfg_rdata), 'h303);
        rd(); check("R7 read w1", int'(cfg_rdata), 'h202);
        rd(); check("R7 read w2", int'(cfg_rdata), 'h00001);
        rd(); check("R7 read wrap", int'(cfg_rdata), 'h303);

        // R8 rewind both cursors (both at w1)
        cyc(1'b1, 1'b0, 1'b1, 0);
        cyc(1'b1, 1'b1, 1'b1, 0);
        cyc(1'b1, 1'b1, 1'b0, 0);
        wr('h000AA);
        check("R8 write cursor rewound", int'(ae_ofs), 'h0AA);
        check("R8 af kept",              int'(af_ofs), 'h202);
        rd(); check("R8 read cursor rewound", int'(cfg_rdata), 'h0AA);

        // R4 independence: reads move only the read cursor
        rd(); check("R4 read w1", int'(cfg_rdata), 'h202);
        rd(); check("R4 read w2", int'(cfg_rdata), 'h00001);
        wr('h000BB);
        check("R4 write cursor unaffected", int'(af_ofs), 'h0BB);
        check("R4 ae kept",                 int'(ae_ofs), 'h0AA);

        // R11 error flag
        fifo_empty = 1'b0;
        wr('h00001);
        check("R11 no flag on ctrl", int'(cfg_wr_err), 0);
        wr('h00111);
        check("R11 flag raised", int'(cfg_wr_err), 1);
        check("R11 write kept",  int'(ae_ofs), 'h111);
        cyc(1'b0, 1'b1, 1'b1, 0);
        check("R11 flag one cycle", int'(cfg_wr_err), 0);

        // R9 no rewind with control bit clear
        wr('h00222); wr('h00000); wr('h00333);
        check("R9 ctrl cleared", int'(ctrl_word), 0);
        cyc(1'b1, 1'b0, 1'b1, 0);
        wr('h00444);
        check("R9 af written, no rewind", int'(af_ofs), 'h444);
        check("R9 ae kept",               int'(ae_ofs), 'h333);

        cyc(1'b1, 1'b1, 1'b1, 0);
        finish_run();
    end

endmodule